// File: doc/BRIEF.md
# Multi-Lane Waveform Table Playback Engine

This block replays a stored waveform at a sample rate sixteen times its own clock. It holds sixteen identical copies of a waveform table, one per lane. Once generation starts, every lane reads one sample on each clock, so a single cycle yields sixteen samples. The lanes are grouped into two port words of eight samples each. Even lanes feed one port and odd lanes feed the other, and each word goes to an external 8:1 serializer.

Each lane has its own start, stop and increment values. In arbitrary playback the increment is forced to the lane count. With lane n starting at address n, each output cycle then carries sixteen consecutive waveform points. In frequency-synthesis playback each lane steps by its own programmed increment instead. A lane that has just read its stop address next returns to its start address. Generation is armed either by a local start command or by an external trigger, chosen by a select input, and it runs until a clear input returns the engine to idle. While idle, every sample slot carries the mid-scale code.

The table write port is accepted only while idle. A write attempted during generation is dropped, and it raises a sticky error flag.

Top module: `lane_wave_player`

## Requirements
- R1: While no generation data is being delivered, `out_valid` is 0 and every 14-bit slot of both `port_a` and `port_b` equals the mid-scale code 8192.
- R2: Slot k of `port_a` (bits 14k+13 down to 14k) carries the sample of lane 2k, and slot k of `port_b` carries the sample of lane 2k+1.
- R3: With `arb_mode`=1, every lane steps by 16 per cycle and ignores `cfg_incr`. With lane n starting at n and stopping at L-16+n for a table of L samples, each output cycle holds sixteen consecutive table entries. All lanes load their start addresses on the same edge.
- R4: A lane that has read its stop address reads its start address on the next cycle. Otherwise its address grows by its increment, modulo the table depth.
- R5: When the start condition is present before rising edge E0, `out_valid` is still 0 after E0 and is 1 after E0+1. The first samples delivered are each lane's start address.
- R6: With `trig_sel`=1, only `ext_trig` starts generation and `start_cmd` has no effect. With `trig_sel`=0, only `start_cmd` starts it and `ext_trig` has no effect.
- R7: `trig_clear` sampled on edge Ec ends generation. `out_valid` remains 1 after Ec and is 0 after Ec+1. A clear present on the same edge as a start condition keeps the engine idle.
- R8: While idle, a write with `tbl_we`=1 stores `tbl_data` at `tbl_addr` in every lane's table copy.
- R9: A write attempted during generation leaves every table copy unchanged and sets `wr_err`. `wr_err` stays 1 until `rst`.
- R10: Start, stop, increment and `arb_mode` are captured when generation starts. Changing them during generation does not alter the running address sequence.
- R11: With `arb_mode`=0, lane n steps by its own field of `cfg_incr`.
- R12: Once started, generation continues after `start_cmd` or `ext_trig` falls, and stops only on `trig_clear` or `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table write address |
| tbl_data | input | 14 | Table write sample |
| cfg_start | input | 96 | Per-lane start addresses, lane n in bits 6n+5:6n |
| cfg_stop | input | 96 | Per-lane stop addresses, same layout |
| cfg_incr | input | 96 | Per-lane increments used when arb_mode=0, same layout |
| arb_mode | input | 1 | 1: fixed step of 16; 0: per-lane increment |
| start_cmd | input | 1 | Local start command |
| ext_trig | input | 1 | External global trigger |
| trig_sel | input | 1 | Start source: 1 external, 0 local |
| trig_clear | input | 1 | Clears the latched start and returns to idle |
| port_a | output | 112 | Even-lane samples, eight 14-bit slots |
| port_b | output | 112 | Odd-lane samples, eight 14-bit slots |
| out_valid | output | 1 | Port words carry table data |
| wr_err | output | 1 | Sticky flag for a write refused during generation |

## Verification
A lane address register that loads late, wraps at the wrong point or steps by the wrong amount shows up in the very first delivered cycle, or at the first wrap. There it appears as a single out-of-order slot in an otherwise consecutive run of sixteen samples. A mismatch in the valid delay shows one cycle early or late as a mid-scale word next to table data. A write that slips through during generation can only be seen when a lane next reads that address, so the bench keeps running until every lane has wrapped. A start gate that listens to the wrong source shows up two edges later as data where mid-scale was expected.

// File: rtl/lwp_pkg.sv
package lwp_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } play_state_e;

    // sequencing command from the controller to every lane
    typedef struct packed {
        logic load;   // capture configuration and jump to start address
        logic step;   // advance one position this cycle
    } seq_cmd_t;

    // code emitted while idle: half of full scale
    function automatic logic [31:0] mid_code(input int width);
        return 32'd1 << (width - 1);
    endfunction

endpackage

// File: rtl/lwp_ctrl.sv
module lwp_ctrl
    import lwp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_cmd,
    input  logic     ext_trig,
    input  logic     trig_sel,
    input  logic     trig_clear,
    input  logic     tbl_we,
    output seq_cmd_t cmd,
    output logic     we_ok,
    output logic     running,
    output logic     vld,
    output logic     wr_err
);

    play_state_e state_q, state_d;
    logic        go;
    logic        vld_q;
    logic        err_q;

    assign go = trig_sel ? ext_trig : start_cmd;

    always_comb begin
        state_d = state_q;
        cmd     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (go && !trig_clear) begin
                    state_d  = ST_RUN;
                    cmd.load = 1'b1;
                end
            end
            ST_RUN: begin
                if (trig_clear) state_d = ST_IDLE;
                else            cmd.step = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vld_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            vld_q   <= (state_q == ST_RUN);
            err_q   <= err_q | (tbl_we && state_q == ST_RUN);
        end
    end

    assign we_ok   = tbl_we && (state_q == ST_IDLE);
    assign running = (state_q == ST_RUN);
    assign vld     = vld_q;
    assign wr_err  = err_q;

endmodule

// File: rtl/lwp_lane.sv
module lwp_lane
    import lwp_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int DEPTH    = 64,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  seq_cmd_t            cmd,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]   cfg_start,
    input  logic [ADDR_W-1:0]   cfg_stop,
    input  logic [ADDR_W-1:0]   cfg_step,
    output logic [SAMPLE_W-1:0] rdata
);

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0]   start_q, stop_q, step_q, addr_q;
    logic [SAMPLE_W-1:0] rdata_q;

    // address sequencer; configuration is frozen at load
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            stop_q  <= '0;
            step_q  <= '0;
            addr_q  <= '0;
        end else if (cmd.load) begin
            start_q <= cfg_start;
            stop_q  <= cfg_stop;
            step_q  <= cfg_step;
            addr_q  <= cfg_start;
        end else if (cmd.step) begin
            addr_q <= (addr_q == stop_q) ? start_q : addr_q + step_q;
        end
    end

    // private table copy, written in parallel with the other lanes
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= mem[addr_q];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/lwp_pack.sv
module lwp_pack
    import lwp_pkg::*;
#(
    parameter int LANES    = 16,
    parameter int SAMPLE_W = 14,
    localparam int HALF    = LANES / 2
) (
    input  logic                       vld,
    input  logic [LANES*SAMPLE_W-1:0]  lane_data,
    output logic [HALF*SAMPLE_W-1:0]   port_a,
    output logic [HALF*SAMPLE_W-1:0]   port_b
);

    localparam logic [SAMPLE_W-1:0] IDLE_CODE = SAMPLE_W'(mid_code(SAMPLE_W));

    for (genvar k = 0; k < HALF; k++) begin : g_slot
        assign port_a[k*SAMPLE_W +: SAMPLE_W] =
            vld ? lane_data[(2*k)*SAMPLE_W +: SAMPLE_W] : IDLE_CODE;
        assign port_b[k*SAMPLE_W +: SAMPLE_W] =
            vld ? lane_data[(2*k+1)*SAMPLE_W +: SAMPLE_W] : IDLE_CODE;
    end

endmodule

// File: rtl/lane_wave_player.sv
module lane_wave_player
    import lwp_pkg::*;
#(
    parameter int LANES    = 16,
    parameter int SAMPLE_W = 14,
    parameter int DEPTH    = 64,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int HALF    = LANES / 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tbl_we,
    input  logic [ADDR_W-1:0]         tbl_addr,
    input  logic [SAMPLE_W-1:0]       tbl_data,
    input  logic [LANES*ADDR_W-1:0]   cfg_start,
    input  logic [LANES*ADDR_W-1:0]   cfg_stop,
    input  logic [LANES*ADDR_W-1:0]   cfg_incr,
    input  logic                      arb_mode,
    input  logic                      start_cmd,
    input  logic                      ext_trig,
    input  logic                      trig_sel,
    input  logic                      trig_clear,
    output logic [HALF*SAMPLE_W-1:0]  port_a,
    output logic [HALF*SAMPLE_W-1:0]  port_b,
    output logic                      out_valid,
    output logic                      wr_err
);

    seq_cmd_t                  cmd;
    logic                      we_ok;
    logic                      running;
    logic                      vld;
    logic [LANES*SAMPLE_W-1:0] lane_data;

    lwp_ctrl i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_cmd  (start_cmd),
        .ext_trig   (ext_trig),
        .trig_sel   (trig_sel),
        .trig_clear (trig_clear),
        .tbl_we     (tbl_we),
        .cmd        (cmd),
        .we_ok      (we_ok),
        .running    (running),
        .vld        (vld),
        .wr_err     (wr_err)
    );

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        logic [ADDR_W-1:0] step_sel;
        // arbitrary playback strides over the whole lane group
        assign step_sel = arb_mode ? ADDR_W'(LANES) : cfg_incr[n*ADDR_W +: ADDR_W];

        lwp_lane #(
            .SAMPLE_W (SAMPLE_W),
            .DEPTH    (DEPTH)
        ) i_lane (
            .clk       (clk),
            .rst       (rst),
            .cmd       (cmd),
            .we        (we_ok),
            .waddr     (tbl_addr),
            .wdata     (tbl_data),
            .cfg_start (cfg_start[n*ADDR_W +: ADDR_W]),
            .cfg_stop  (cfg_stop[n*ADDR_W +: ADDR_W]),
            .cfg_step  (step_sel),
            .rdata     (lane_data[n*SAMPLE_W +: SAMPLE_W])
        );
    end

    lwp_pack #(
        .LANES    (LANES),
        .SAMPLE_W (SAMPLE_W)
    ) i_pack (
        .vld       (vld),
        .lane_data (lane_data),
        .port_a    (port_a),
        .port_b    (port_b)
    );

    assign out_valid = vld;

endmodule

// File: rtl/lane_wave_player_chk.sv
module lane_wave_player_chk #(
    parameter int LANES    = 16,
    parameter int SAMPLE_W = 14,
    localparam int HALF    = LANES / 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start_cmd,
    input logic                      ext_trig,
    input logic                      trig_sel,
    input logic                      trig_clear,
    input logic                      tbl_we,
    input logic                      running,
    input logic                      out_valid,
    input logic                      wr_err,
    input logic [HALF*SAMPLE_W-1:0]  port_a,
    input logic [HALF*SAMPLE_W-1:0]  port_b
);

    localparam logic [SAMPLE_W-1:0]      MID  = SAMPLE_W'(1) << (SAMPLE_W - 1);
    localparam logic [HALF*SAMPLE_W-1:0] IDLE = {HALF{MID}};

    AST_IDLE_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (port_a == IDLE && port_b == IDLE));  // R1

    AST_START_TO_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |=> out_valid);  // R5

    AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (rst)
        trig_clear |=> ##1 !out_valid);  // R7

    AST_EXT_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!running && trig_sel && !ext_trig) |=> !running);  // R6

    AST_LOCAL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!running && !trig_sel && !start_cmd) |=> !running);  // R6

    AST_RUN_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (running && !trig_clear) |=> running);  // R12

    AST_BLOCKED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (tbl_we && running) |=> wr_err);  // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> wr_err);  // R9

endmodule

bind lane_wave_player lane_wave_player_chk #(
    .LANES    (LANES),
    .SAMPLE_W (SAMPLE_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .start_cmd  (start_cmd),
    .ext_trig   (ext_trig),
    .trig_sel   (trig_sel),
    .trig_clear (trig_clear),
    .tbl_we     (tbl_we),
    .running    (running),
    .out_valid  (out_valid),
    .wr_err     (wr_err),
    .port_a     (port_a),
    .port_b     (port_b)
);

// File: tb/test_lane_wave_player.sv
module test_lane_wave_player;

    localparam int LANES = 16;
    localparam int SW    = 14;
    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int HALF  = LANES / 2;
    localparam int MID   = 8192;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  tbl_we = 1'b0;
    logic [AW-1:0]         tbl_addr = '0;
    logic [SW-1:0]         tbl_data = '0;
    logic [LANES*AW-1:0]   cfg_start = '0, cfg_stop = '0, cfg_incr = '0;
    logic                  arb_mode = 1'b1;
    logic                  start_cmd = 1'b0, ext_trig = 1'b0;
    logic                  trig_sel = 1'b0, trig_clear = 1'b0;
    logic [HALF*SW-1:0]    port_a, port_b;
    logic                  out_valid, wr_err;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    int tb_mem [DEPTH];
    int m_start [LANES], m_stop [LANES], m_step [LANES], m_cur [LANES];

    always #2.5 clk = ~clk;

    lane_wave_player #(.LANES(LANES), .SAMPLE_W(SW), .DEPTH(DEPTH)) i_lane_wave_player (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .cfg_start(cfg_start), .cfg_stop(cfg_stop), .cfg_incr(cfg_incr),
        .arb_mode(arb_mode), .start_cmd(start_cmd), .ext_trig(ext_trig),
        .trig_sel(trig_sel), .trig_clear(trig_clear),
        .port_a(port_a), .port_b(port_b), .out_valid(out_valid), .wr_err(wr_err)
    );

    function automatic int pat(int a);
        return (a * 331 + 77) % 16384;
    endfunction

    task automatic check_val(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int slot(int n);
        if (n % 2 == 0) return int'(port_a[(n/2)*SW +: SW]);
        return int'(port_b[(n/2)*SW +: SW]);
    endfunction

    task automatic check_idle(string tag);
        check_val({tag, " valid"}, int'(out_valid), 0);
        for (int n = 0; n < LANES; n++) check_val({tag, " midscale"}, slot(n), MID);
    endtask

    // requirement model: capture at start (R10), step/wrap (R4)
    task automatic model_load();
        for (int n = 0; n < LANES; n++) begin
            m_start[n] = int'(cfg_start[n*AW +: AW]);
            m_stop[n]  = int'(cfg_stop[n*AW +: AW]);
            m_step[n]  = arb_mode ? LANES : int'(cfg_incr[n*AW +: AW]);
            m_cur[n]   = m_start[n];
        end
    endtask

    task automatic model_step();
        for (int n = 0; n < LANES; n++)
            m_cur[n] = (m_cur[n] == m_stop[n]) ? m_start[n] : (m_cur[n] + m_step[n]) % DEPTH;
    endtask

    task automatic check_lanes(string tag);
        check_val({tag, " valid"}, int'(out_valid), 1);
        for (int n = 0; n < LANES; n++) check_val(tag, slot(n), tb_mem[m_cur[n]]);
        model_step();
    endtask

    task automatic set_arb_cfg();
        arb_mode = 1'b1;
        for (int n = 0; n < LANES; n++) begin
            cfg_start[n*AW +: AW] = AW'(n);
            cfg_stop[n*AW +: AW]  = AW'(DEPTH - LANES + n);
            cfg_incr[n*AW +: AW]  = AW'(3);
        end
    endtask

    // pulse the chosen source; returns at the negedge after E0+1
    task automatic fire(bit use_ext);
        @(negedge clk);
        if (use_ext) ext_trig = 1'b1; else start_cmd = 1'b1;
        model_load();
        @(negedge clk);
        ext_trig = 1'b0; start_cmd = 1'b0;
        check_val("R5 no data after first edge", int'(out_valid), 0);
        @(negedge clk);
    endtask

    task automatic clear_run();
        trig_clear = 1'b1;
        @(negedge clk);
        trig_clear = 1'b0;
        check_val("R7 valid holds one edge after clear", int'(out_valid), 1);
        @(negedge clk);
        check_idle("R7 after clear");
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 reset");
        check_val("R9 error clear at reset", int'(wr_err), 0);
    endtask

    task automatic t_load_table();
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            tbl_we = 1'b1; tbl_addr = AW'(a); tbl_data = SW'(pat(a));
            tb_mem[a] = pat(a);
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic t_arb_local();
        set_arb_cfg();
        trig_sel = 1'b0;
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
        @(negedge clk);
        check_idle("R6 ext_trig ignored when local");
        fire(1'b0);
        // first cycle must be table entries 0..15 in lane order (R3, R2)
        for (int n = 0; n < LANES; n++) check_val("R3 R2 consecutive first word", slot(n), tb_mem[n]);
        for (int j = 0; j < 9; j++) begin
            check_lanes("R3 R4 R12 arbitrary playback");
            @(negedge clk);
        end
        clear_run();
    endtask

    task automatic t_ext();
        trig_sel = 1'b1;
        @(negedge clk); start_cmd = 1'b1;
        @(negedge clk); start_cmd = 1'b0;
        @(negedge clk);
        check_idle("R6 start_cmd ignored when external");
        fire(1'b1);
        check_lanes("R6 external start");
        @(negedge clk);
        check_lanes("R6 external run");
        clear_run();
        trig_sel = 1'b0;
    endtask

    task automatic t_cfg_sampled();
        set_arb_cfg();
        fire(1'b0);
        check_lanes("R10 before change");
        arb_mode = 1'b0;
        for (int n = 0; n < LANES; n++) begin
            cfg_start[n*AW +: AW] = '0; cfg_stop[n*AW +: AW] = '0; cfg_incr[n*AW +: AW] = AW'(1);
        end
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            check_lanes("R10 config change ignored");
        end
        @(negedge clk);
        clear_run();
    endtask

    task automatic t_write_run();
        set_arb_cfg();
        fire(1'b0);
        check_lanes("R9 run before write");
        tbl_we = 1'b1; tbl_addr = '0; tbl_data = 14'h1234;
        @(negedge clk);
        tbl_we = 1'b0;
        check_val("R9 error flag set", int'(wr_err), 1);
        for (int j = 0; j < 6; j++) begin
            check_lanes("R9 table unchanged");
            @(negedge clk);
        end
        clear_run();
        repeat (2) @(negedge clk);
        check_val("R9 error flag sticky", int'(wr_err), 1);
    endtask

    task automatic t_dds();
        arb_mode = 1'b0;
        for (int n = 0; n < LANES; n++) begin
            cfg_start[n*AW +: AW] = AW'(4 * n);
            cfg_incr[n*AW +: AW]  = AW'(1 + n % 3);
            cfg_stop[n*AW +: AW]  = AW'(4 * n + 2 * (1 + n % 3));
        end
        fire(1'b0);
        for (int j = 0; j < 7; j++) begin
            check_lanes("R11 R4 per-lane increment");
            @(negedge clk);
        end
        clear_run();
    endtask

    task automatic t_idle_write();
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = AW'(5); tbl_data = 14'h2A5C;
        tb_mem[5] = 'h2A5C;
        @(negedge clk);
        tbl_we = 1'b0;
        set_arb_cfg();
        fire(1'b0);
        check_val("R8 idle write visible on lane 5", slot(5), 'h2A5C);
        check_lanes("R8 idle write run");
        @(negedge clk);
        clear_run();
    endtask

    task automatic t_clear_priority();
        @(negedge clk);
        start_cmd = 1'b1; trig_clear = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0; trig_clear = 1'b0;
        @(negedge clk);
        check_idle("R7 clear beats start");
        @(negedge clk);
        check_idle("R7 still idle");
    endtask

    initial begin
        t_reset();
        t_load_table();
        t_arb_local();
        t_ext();
        t_cfg_sampled();
        t_write_run();
        t_dds();
        t_idle_write();
        t_clear_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1..R12 run did not complete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule